// File: doc/BRIEF.md
# Framed Serial Port Transceiver

A full-duplex synchronous serial port. The transmit section makes its own bit clock from the system clock and drives a frame strobe and a data line. The receive section takes a bit clock, a frame strobe and a data line from the wire and oversamples them in the system clock domain. Software writes outgoing words into a transmit holding register and reads incoming words from a receive holding register. Each holding register sits in front of its own shift register, so one word can wait while another is on the wire.

Packets are 8, 10, 12 or 16 bits long and are sent most significant bit first. In burst framing every packet gets its own frame pulse. In continuous framing only the first packet of a stream gets a pulse, and the later packets follow with no gap. The polarity of the bit clock and of the frame strobe is set by configuration. Each direction raises a one-cycle interrupt pulse per word, and each pulse has its own enable. A sticky flag reports a receive overrun. Another flag reports a transmit underrun in continuous framing, when the last word is sent again.

Top module: `fsp_xcvr`

## Requirements
- R1: A word written with tx_wr comes out on ser_tx_dat most significant packet bit first, and when the port is looped back it appears unchanged in rx_rdata with rx_avail set.
- R2: The transmit side is double-buffered. tx_empty returns to 1 once the held word has moved into the shift register, and a second word written then is sent right after the first, with both received in order.
- R3: cfg_len selects the packet length: 0 gives 8 bits, 1 gives 10, 2 gives 12 and 3 gives 16. The packet is the low bits of the 16-bit data word, and received bits above the packet length read as zero.
- R4: With cfg_cont=0 (burst), each packet gets exactly one frame pulse, and the pulse is active during the bit period of the packet's most significant bit.
- R5: With cfg_cont=1 (continuous), a stream of back-to-back words carries one frame pulse only, on its first word.
- R6: With cfg_clk_pol=1 the bit clock is inverted, so it idles high and the receiver samples on its rising edge. With cfg_fs_pol=1 the frame strobe is active low and idles high.
- R7: tx_irq is a one-cycle pulse when the holding word moves into the transmit shift register. rx_irq is a one-cycle pulse when a completed packet moves into rx_rdata. cfg_tx_ie and cfg_rx_ie gate these pulses without affecting data transfer.
- R8: The generated bit clock has a period of CLK_DIV system clocks. CLK_DIV must be even and at least 4, which keeps the bit rate at or below a quarter of the system clock.
- R9: If a packet completes while rx_avail is still 1, rx_overrun is set and stays set, and rx_rdata takes the new word. rx_rd clears both rx_avail and rx_overrun.
- R10: In continuous framing, if no new word is held at a packet boundary, the last word is sent again and tx_underrun is set. The next tx_wr clears it.
- R11: After reset tx_empty=1, rx_avail=0, both flags and both interrupt pulses are 0, and the bit clock and frame strobe sit at their inactive levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tx_en | input | 1 | Transmit section enable; low stops the bit clock and clears framing state |
| cfg_rx_en | input | 1 | Receive section enable |
| cfg_len | input | 2 | Packet length code (0:8, 1:10, 2:12, 3:16 bits) |
| cfg_cont | input | 1 | 1 selects continuous framing, 0 selects burst framing |
| cfg_clk_pol | input | 1 | Bit clock polarity, 1 inverts |
| cfg_fs_pol | input | 1 | Frame strobe polarity, 1 makes it active low |
| cfg_tx_ie | input | 1 | Transmit interrupt enable |
| cfg_rx_ie | input | 1 | Receive interrupt enable |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_wdata | input | W | Transmit word |
| tx_empty | output | 1 | Transmit holding register can take a word |
| tx_underrun | output | 1 | Sticky underrun flag |
| tx_irq | output | 1 | Transmit-ready pulse |
| rx_rd | input | 1 | Read strobe for the receive holding register |
| rx_rdata | output | W | Received word |
| rx_avail | output | 1 | Receive holding register holds an unread word |
| rx_overrun | output | 1 | Sticky overrun flag |
| rx_irq | output | 1 | Receive-ready pulse |
| ser_tx_clk | output | 1 | Transmit bit clock |
| ser_tx_fs | output | 1 | Transmit frame strobe |
| ser_tx_dat | output | 1 | Transmit serial data |
| ser_rx_clk | input | 1 | Receive bit clock |
| ser_rx_fs | input | 1 | Receive frame strobe |
| ser_rx_dat | input | 1 | Receive serial data |

## Verification
A wrong bit counter or alignment in either shift path shows up at the very next receive completion: in loopback the word in rx_rdata comes out shifted or truncated, within one packet time. A framing state that is stuck or cleared at the wrong moment shows up as a frame pulse that is extra or missing within one packet period, and this is visible as a count of pulses on ser_tx_fs. Mistakes in the holding-register bookkeeping show up as interrupt counts that do not match the number of words written, or as flags that are wrong right after the following read or write.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
   typedef enum logic [1:0] {
      PKT_8  = 2'd0,
      PKT_10 = 2'd1,
      PKT_12 = 2'd2,
      PKT_16 = 2'd3
   } pkt_len_e;

   // number of bits in one packet for a length code
   function automatic logic [4:0] pkt_bits(input logic [1:0] code);
      case (pkt_len_e'(code))
         PKT_8:   return 5'd8;
         PKT_10:  return 5'd10;
         PKT_12:  return 5'd12;
         default: return 5'd16;
      endcase
   endfunction
endpackage

// File: rtl/fsp_bitclk.sv
module fsp_bitclk #(
   parameter int CLK_DIV = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic sclk_raw,
   output logic rise_now
);
   localparam int HALF = CLK_DIV / 2;
   localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF - 1);

   initial assert (CLK_DIV >= 4 && (CLK_DIV % 2) == 0)
      else $error("fsp_bitclk: CLK_DIV must be even and at least 4");

   logic [CW-1:0] cnt;
   logic          wrap;

   assign wrap     = en && (cnt == LAST);
   assign rise_now = wrap && !sclk_raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         sclk_raw <= 1'b0;
      end else if (!en) begin
         cnt      <= '0;
         sclk_raw <= 1'b0;
      end else if (wrap) begin
         cnt      <= '0;
         sclk_raw <= ~sclk_raw;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // R8: once the clock rises it holds for at least one more system clock
   a_r8_half_period: assert property (@(posedge clk) disable iff (!rst_n || !en)
      $rose(sclk_raw) |=> sclk_raw);
endmodule

// File: rtl/fsp_tx.sv
module fsp_tx #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         cont,
   input  logic [1:0]   len_code,
   input  logic         ie,
   input  logic         rise,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   output logic         dat,
   output logic         fs_act,
   output logic         irq,
   output logic         empty,
   output logic         urun
);
   localparam logic [4:0] WL = 5'(W);

   initial assert (W >= 16 && W <= 31)
      else $error("fsp_tx: W must lie between 16 and 31");

   logic [W-1:0] hold, shreg, last_word;
   logic         hold_v, stream;
   logic [4:0]   left;
   logic [4:0]   plen;

   assign plen  = fsp_pkg::pkt_bits(len_code);
   assign dat   = shreg[W-1];
   assign empty = !hold_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold      <= '0;
         shreg     <= '0;
         last_word <= '0;
         hold_v    <= 1'b0;
         stream    <= 1'b0;
         left      <= '0;
         fs_act    <= 1'b0;
         irq       <= 1'b0;
         urun      <= 1'b0;
      end else begin
         irq <= 1'b0;
         if (!en) begin
            shreg  <= '0;
            left   <= '0;
            stream <= 1'b0;
            fs_act <= 1'b0;
         end else if (rise) begin
            if (left > 5'd1) begin
               shreg  <= shreg << 1;
               left   <= left - 5'd1;
               fs_act <= 1'b0;
            end else if (hold_v) begin
               shreg     <= hold << (WL - plen);
               last_word <= hold;
               hold_v    <= 1'b0;
               left      <= plen;
               fs_act    <= !stream;
               stream    <= cont;
               irq       <= ie;
            end else if (stream && cont) begin
               shreg  <= last_word << (WL - plen);
               left   <= plen;
               fs_act <= 1'b0;
               urun   <= 1'b1;
            end else begin
               shreg  <= '0;
               left   <= '0;
               fs_act <= 1'b0;
               stream <= 1'b0;
            end
         end
         if (!cont) stream <= 1'b0;
         if (wr) begin
            hold   <= wdata;
            hold_v <= 1'b1;
            urun   <= 1'b0;
         end
      end
   end

   // R7: transmit interrupt is a single-cycle pulse
   a_r7_tx_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
   // R2: an interrupt only follows a load from a full holding register
   a_r2_load_from_full: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(hold_v));
   // R5: a frame pulse never starts inside a running stream
   a_r5_no_fs_midstream: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fs_act) |-> !$past(stream));
   // R10: underrun only arises in continuous framing
   a_r10_urun_cont: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(urun) |-> $past(cont));
endmodule

// File: rtl/fsp_rx.sv
module fsp_rx #(
   parameter int W     = 16,
   parameter int NSYNC = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         cont,
   input  logic [1:0]   len_code,
   input  logic         clk_pol,
   input  logic         fs_pol,
   input  logic         ie,
   input  logic         sclk_i,
   input  logic         fs_i,
   input  logic         dat_i,
   input  logic         rd,
   output logic [W-1:0] rdata,
   output logic         avail,
   output logic         ovr,
   output logic         irq
);
   initial assert (NSYNC >= 2 && W >= 16)
      else $error("fsp_rx: NSYNC must be at least 2 and W at least 16");

   logic [2:0] pins_in, pins_s;
   assign pins_in = {sclk_i, fs_i, dat_i};

   for (genvar g = 0; g < 3; g++) begin : g_sync
      logic [NSYNC-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[NSYNC-2:0], pins_in[g]};
      end
      assign pins_s[g] = chain[NSYNC-1];
   end

   logic         sclk_n, sclk_prev, sample, framed, start, take;
   logic [W-1:0] shreg, nsh;
   logic [4:0]   cnt, ncnt, plen;
   logic         stream;

   assign plen   = fsp_pkg::pkt_bits(len_code);
   assign sclk_n = pins_s[2] ^ clk_pol;
   assign sample = en && sclk_prev && !sclk_n;

   always_comb begin
      framed = pins_s[1] ^ fs_pol;
      start  = framed || (cnt == 5'd0 && stream);
      take   = sample && (start || cnt != 5'd0);
      nsh    = start ? {{(W-1){1'b0}}, pins_s[0]} : {shreg[W-2:0], pins_s[0]};
      ncnt   = start ? 5'd1 : cnt + 5'd1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_prev <= 1'b0;
         shreg     <= '0;
         cnt       <= '0;
         stream    <= 1'b0;
         rdata     <= '0;
         avail     <= 1'b0;
         ovr       <= 1'b0;
         irq       <= 1'b0;
      end else begin
         sclk_prev <= sclk_n;
         irq       <= 1'b0;
         if (rd) begin
            avail <= 1'b0;
            ovr   <= 1'b0;
         end
         if (!en) begin
            cnt    <= '0;
            stream <= 1'b0;
         end else if (take) begin
            if (framed) stream <= cont;
            if (ncnt == plen) begin
               rdata <= nsh;
               avail <= 1'b1;
               ovr   <= ovr | (avail & !rd);
               irq   <= ie;
               cnt   <= '0;
            end else begin
               shreg <= nsh;
               cnt   <= ncnt;
            end
         end
         if (!cont) stream <= 1'b0;
      end
   end

   // R7: receive interrupt is a single-cycle pulse
   a_r7_rx_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
   // R9: an overrun is only reported while an unread word is held
   a_r9_ovr_avail: assert property (@(posedge clk) disable iff (!rst_n)
      ovr |-> avail);
endmodule

// File: rtl/fsp_xcvr.sv
module fsp_xcvr #(
   parameter int W       = 16,
   parameter int CLK_DIV = 8,
   parameter int NSYNC   = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cfg_tx_en,
   input  logic         cfg_rx_en,
   input  logic [1:0]   cfg_len,
   input  logic         cfg_cont,
   input  logic         cfg_clk_pol,
   input  logic         cfg_fs_pol,
   input  logic         cfg_tx_ie,
   input  logic         cfg_rx_ie,
   input  logic         tx_wr,
   input  logic [W-1:0] tx_wdata,
   output logic         tx_empty,
   output logic         tx_underrun,
   output logic         tx_irq,
   input  logic         rx_rd,
   output logic [W-1:0] rx_rdata,
   output logic         rx_avail,
   output logic         rx_overrun,
   output logic         rx_irq,
   output logic         ser_tx_clk,
   output logic         ser_tx_fs,
   output logic         ser_tx_dat,
   input  logic         ser_rx_clk,
   input  logic         ser_rx_fs,
   input  logic         ser_rx_dat
);
   logic sclk_raw, rise_now, fs_act;

   fsp_bitclk #(.CLK_DIV(CLK_DIV)) u_bitclk (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (cfg_tx_en),
      .sclk_raw (sclk_raw),
      .rise_now (rise_now)
   );

   fsp_tx #(.W(W)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (cfg_tx_en),
      .cont     (cfg_cont),
      .len_code (cfg_len),
      .ie       (cfg_tx_ie),
      .rise     (rise_now),
      .wr       (tx_wr),
      .wdata    (tx_wdata),
      .dat      (ser_tx_dat),
      .fs_act   (fs_act),
      .irq      (tx_irq),
      .empty    (tx_empty),
      .urun     (tx_underrun)
   );

   fsp_rx #(.W(W), .NSYNC(NSYNC)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (cfg_rx_en),
      .cont     (cfg_cont),
      .len_code (cfg_len),
      .clk_pol  (cfg_clk_pol),
      .fs_pol   (cfg_fs_pol),
      .ie       (cfg_rx_ie),
      .sclk_i   (ser_rx_clk),
      .fs_i     (ser_rx_fs),
      .dat_i    (ser_rx_dat),
      .rd       (rx_rd),
      .rdata    (rx_rdata),
      .avail    (rx_avail),
      .ovr      (rx_overrun),
      .irq      (rx_irq)
   );

   assign ser_tx_clk = sclk_raw ^ cfg_clk_pol;
   assign ser_tx_fs  = fs_act ^ cfg_fs_pol;

   // R6: while the transmitter is off the wire sits at the inactive levels
   a_r6_idle_levels: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_tx_en && !$past(cfg_tx_en) && $stable(cfg_clk_pol) && $stable(cfg_fs_pol)
         |-> (ser_tx_clk == cfg_clk_pol) && (ser_tx_fs == cfg_fs_pol));
endmodule

// File: tb/fsp_xcvr_tb.sv
module fsp_xcvr_tb;
   localparam int CLK_DIV = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tx_en = 1'b0, rx_en = 1'b0;
   logic [1:0]  len = 2'd3;
   logic        cont = 1'b0, cpol = 1'b0, fpol = 1'b0, tie = 1'b1, rie = 1'b1;
   logic        tx_wr = 1'b0, rx_rd = 1'b0;
   logic [15:0] tx_wdata = '0;
   logic        tx_empty, tx_underrun, tx_irq, rx_avail, rx_overrun, rx_irq;
   logic [15:0] rx_rdata;
   logic        s_clk, s_fs, s_dat;

   always #5 clk = ~clk;

   fsp_xcvr #(.W(16), .CLK_DIV(CLK_DIV), .NSYNC(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_tx_en(tx_en), .cfg_rx_en(rx_en),
      .cfg_len(len), .cfg_cont(cont), .cfg_clk_pol(cpol), .cfg_fs_pol(fpol),
      .cfg_tx_ie(tie), .cfg_rx_ie(rie), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
      .tx_empty(tx_empty), .tx_underrun(tx_underrun), .tx_irq(tx_irq),
      .rx_rd(rx_rd), .rx_rdata(rx_rdata), .rx_avail(rx_avail),
      .rx_overrun(rx_overrun), .rx_irq(rx_irq), .ser_tx_clk(s_clk),
      .ser_tx_fs(s_fs), .ser_tx_dat(s_dat), .ser_rx_clk(s_clk),
      .ser_rx_fs(s_fs), .ser_rx_dat(s_dat)
   );

   int total = 0, bad = 0, cycles = 0;
   int fs_cnt = 0, txi_cnt = 0, rxi_cnt = 0;
   logic fs_prev = 1'b0, fs_bit = 1'b0;
   bit done = 0;

   // monitors, sampled away from the active edge
   always @(negedge clk) begin
      cycles <= cycles + 1;
      if (tx_irq) txi_cnt <= txi_cnt + 1;
      if (rx_irq) rxi_cnt <= rxi_cnt + 1;
      fs_prev <= s_fs ^ fpol;
      if ((s_fs ^ fpol) && !fs_prev && tx_en) begin
         fs_cnt <= fs_cnt + 1;
         fs_bit <= s_dat;
      end
   end

   initial begin
      wait (cycles > 150000);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: act=hung exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic setup(input logic [1:0] l, input logic c, input logic cp,
                        input logic fp, input logic ti, input logic ri);
      @(negedge clk);
      tx_en = 1'b0; rx_en = 1'b0;
      repeat (2) @(negedge clk);
      len = l; cont = c; cpol = cp; fpol = fp; tie = ti; rie = ri;
      repeat (10) @(negedge clk);
      tx_en = 1'b1; rx_en = 1'b1;
   endtask

   task automatic write_word(input logic [15:0] w);
      tx_wdata = w; tx_wr = 1'b1;
      @(negedge clk);
      tx_wr = 1'b0;
   endtask

   task automatic wait_empty();
      for (int k = 0; k < 3000; k++) begin
         @(negedge clk);
         if (tx_empty) break;
      end
   endtask

   task automatic wait_avail(output bit ok);
      ok = 0;
      for (int k = 0; k < 3000; k++) begin
         @(negedge clk);
         if (rx_avail) begin ok = 1; break; end
      end
   endtask

   task automatic read_word(output logic [15:0] v);
      v = rx_rdata; rx_rd = 1'b1;
      @(negedge clk);
      rx_rd = 1'b0;
   endtask

   function automatic int bitpos(input logic [1:0] l);
      case (l)
         2'd0: return 7;
         2'd1: return 9;
         2'd2: return 11;
         default: return 15;
      endcase
   endfunction

   // {len, cont, clk_pol, fs_pol, word, expected}
   localparam logic [36:0] VEC [6] = '{
      {2'd3, 1'b0, 1'b0, 1'b0, 16'hA5C3, 16'hA5C3},
      {2'd0, 1'b0, 1'b0, 1'b0, 16'hFF5A, 16'h005A},
      {2'd1, 1'b0, 1'b1, 1'b0, 16'hFFFF, 16'h03FF},
      {2'd2, 1'b0, 1'b0, 1'b1, 16'h1234, 16'h0234},
      {2'd3, 1'b0, 1'b1, 1'b1, 16'h8001, 16'h8001},
      {2'd2, 1'b1, 1'b0, 1'b0, 16'hFABC, 16'h0ABC}
   };

   initial begin
      bit ok;
      logic [15:0] v;
      int t0, f0, r0;

      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 tx_empty", 32'(tx_empty), 1);
      chk("R11 rx_avail", 32'(rx_avail), 0);
      chk("R11 flags", {30'd0, tx_underrun, rx_overrun}, 0);
      chk("R11 irqs", {30'd0, tx_irq, rx_irq}, 0);
      chk("R11 wire idle", {30'd0, s_clk, s_fs}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // table walk: R1 R3 R4 R6
      for (int i = 0; i < 6; i++) begin
         setup(VEC[i][36:35], VEC[i][34], VEC[i][33], VEC[i][32], 1'b1, 1'b1);
         f0 = fs_cnt; t0 = txi_cnt;
         write_word(VEC[i][31:16]);
         wait_avail(ok);
         chk($sformatf("R1 R3 vector %0d avail", i), 32'(ok), 1);
         read_word(v);
         chk($sformatf("R1 R3 vector %0d data", i), 32'(v), 32'(VEC[i][15:0]));
         chk($sformatf("R4 vector %0d fs count", i), 32'(fs_cnt - f0), 1);
         chk($sformatf("R4 vector %0d fs on msb", i), 32'(fs_bit),
             32'(VEC[i][15 - 15 + bitpos(VEC[i][36:35])]));
         chk($sformatf("R7 vector %0d tx_irq", i), 32'(txi_cnt - t0), 1);
      end

      // R6 idle levels with both polarities inverted, transmitter off
      setup(2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
      tx_en = 1'b0; rx_en = 1'b0;
      repeat (4) @(negedge clk);
      chk("R6 idle clk high", 32'(s_clk), 1);
      chk("R6 idle fs high", 32'(s_fs), 1);

      // R8 bit clock period
      setup(2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
      while (s_clk !== 1'b1) @(negedge clk);
      while (s_clk !== 1'b0) @(negedge clk);
      t0 = cycles;
      while (s_clk !== 1'b1) @(negedge clk);
      while (s_clk !== 1'b0) @(negedge clk);
      chk("R8 period", 32'(cycles - t0), CLK_DIV);

      // R2 R4 burst double buffering
      setup(2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
      f0 = fs_cnt; t0 = txi_cnt; r0 = rxi_cnt;
      write_word(16'h1357);
      wait_empty();
      write_word(16'h9BDF);
      wait_avail(ok);
      read_word(v);
      chk("R2 first word", 32'(v), 32'h1357);
      wait_avail(ok);
      read_word(v);
      chk("R2 second word", 32'(v), 32'h9BDF);
      chk("R4 burst fs pulses", 32'(fs_cnt - f0), 2);
      chk("R7 tx_irq count", 32'(txi_cnt - t0), 2);
      chk("R7 rx_irq count", 32'(rxi_cnt - r0), 2);

      // R5 continuous stream, then R10 underrun
      setup(2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
      f0 = fs_cnt;
      write_word(16'h0111);
      wait_empty();
      write_word(16'h0A22);
      wait_avail(ok);
      read_word(v);
      chk("R5 stream word 0", 32'(v), 32'h0111);
      wait_empty();
      write_word(16'h0C33);
      wait_avail(ok);
      read_word(v);
      chk("R5 stream word 1", 32'(v), 32'h0A22);
      chk("R10 no underrun while fed", 32'(tx_underrun), 0);
      wait_avail(ok);
      read_word(v);
      chk("R5 stream word 2", 32'(v), 32'h0C33);
      wait_avail(ok);
      read_word(v);
      chk("R10 resent word", 32'(v), 32'h0C33);
      chk("R10 underrun flag", 32'(tx_underrun), 1);
      chk("R5 single fs pulse", 32'(fs_cnt - f0), 1);
      write_word(16'h0444);
      chk("R10 cleared by write", 32'(tx_underrun), 0);

      // R9 overrun
      setup(2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
      r0 = rxi_cnt;
      write_word(16'h0033);
      wait_empty();
      write_word(16'h00C6);
      for (int k = 0; k < 3000 && (rxi_cnt - r0) < 2; k++) @(negedge clk);
      chk("R9 overrun set", 32'(rx_overrun), 1);
      chk("R9 newest word kept", 32'(rx_rdata), 32'h00C6);
      read_word(v);
      chk("R9 cleared by read", {30'd0, rx_overrun, rx_avail}, 0);

      // R7 masked interrupts still move data
      setup(2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      t0 = txi_cnt; r0 = rxi_cnt;
      write_word(16'h02A5);
      wait_avail(ok);
      read_word(v);
      chk("R7 masked data", 32'(v), 32'h02A5);
      chk("R7 masked irqs", 32'((txi_cnt - t0) + (rxi_cnt - r0)), 0);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule